// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a small register-mapped countdown timer meant to be placed once beside every processor core. A programmable prescaler divides the input clock into ticks. An interval counter counts those ticks down from a value held in a buffer register. When the count runs out, the timer sets a status flag and, if allowed, raises its interrupt line.

The timer runs in one of two ways. In auto-reload mode it reloads itself and fires again every period until software clears the start bit. In single-shot mode it fires once and then stays idle until it is stopped and started again. Counting and interrupt delivery have separate start bits. Every write to a tick, interval or control register leaves a write-complete flag that software acknowledges by writing a one to it.

Software places instances at a fixed stride; instance n sits at 0x300 + 0x100·n. The address decode for this stride is outside the block, and the block sees only the byte offset within its own instance. Intervals from 0xF to 0x7FFFFFFF are the range meant for use.

Top module: `core_tick_timer`

## Requirements
- R1: After reset, reads at offsets 0x00, 0x08, 0x20, 0x30, 0x34 and 0x40 all return zero and `irq` is low; unmapped offsets read zero.
- R2: A prescaler value T at offset 0x00 makes one tick every T+1 clocks. With interval N, the first expiry sets status on the clock edge N·(T+1) edges after the edge that writes the start bit.
- R3: A write to offset 0x08 loads bits 30:0 as the new interval only when bit 31 is one; with bit 31 zero the stored interval is unchanged. Bit 31 reads back as zero.
- R4: `irq` is high exactly when status bit 0 (offset 0x30), enable bit 0 (offset 0x34) and interrupt-start bit 1 of control (offset 0x20) are all one.
- R5: Status bit 0 is set on expiry and stays set until a write to 0x30 with data bit 0 set clears it. A write with bit 0 zero leaves it alone. An expiry in the same cycle as a clear wins.
- R6: With control bit 2 (auto-reload) zero, the timer expires once and then does not expire again until the run bit is cleared and set again.
- R7: With control bit 2 one, the timer expires every N·(T+1) clocks while running.
- R8: Writes to 0x00, 0x08 and 0x20 set write-status bits 0, 1 and 3 of offset 0x40 on the next edge. A bit 0x08 write sets its flag whether or not bit 31 is set. Writing a one to a bit of 0x40 clears that flag, and writing a zero has no effect.
- R9: Clearing control bit 0 (run) halts the prescaler and the interval counter. The next start begins a full fresh period from both buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset within the instance |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that `addr` and `wdata` are only meaningful while `wr_en` is high. They also assume the prescaler value does not change while the timer runs, so the tick spacing stays fixed. The stimulus writes the prescaler and interval only while the run bit is clear, and it keeps each period at two clocks or more. This keeps a status clear from landing on the same edge as an expiry, except where that overlap is the point of the check.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam logic [7:0] OFS_TICK = 8'h00;
  localparam logic [7:0] OFS_IVAL = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h20;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_IEN  = 8'h34;
  localparam logic [7:0] OFS_WST  = 8'h40;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_IRQ  = 1;
  localparam int CTRL_AUTO = 2;
  localparam int WST_TICK  = 0;
  localparam int WST_IVAL  = 1;
  localparam int WST_CTRL  = 3;

  // prescaler reaches its last count (>= guards a shrinking divider)
  function automatic logic at_wrap(input logic [31:0] cnt, input logic [31:0] div);
    return cnt >= div;
  endfunction

  // interval counter on its final tick
  function automatic logic is_last(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction
endpackage

// File: rtl/ctt_prescaler.sv
module ctt_prescaler #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TICK_W-1:0] div,
  output logic              tick
);
  import ctt_pkg::*;
  logic [TICK_W-1:0] cnt;

  assign tick = run && at_wrap(32'(cnt), 32'(div));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ctt_interval.sv
module ctt_interval #(
  parameter int IVAL_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [IVAL_W-1:0] reload,
  input  logic              auto_mode,
  output logic              expire
);
  import ctt_pkg::*;
  logic [IVAL_W-1:0] cnt;
  logic              armed;

  assign expire = run && armed && tick && is_last(32'(cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!run) begin
      cnt   <= reload;
      armed <= 1'b1;
    end else if (tick && armed) begin
      if (is_last(32'(cnt))) begin
        cnt   <= reload;
        armed <= auto_mode;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctt_regs.sv
module ctt_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TICK_W = 32,
  parameter int IVAL_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [TICK_W-1:0] tick_div,
  output logic [IVAL_W-1:0] ival,
  output logic              run,
  output logic              int_start,
  output logic              auto_mode,
  output logic              status,
  output logic              irq_en,
  output logic [3:0]        wstat,
  output logic [DATA_W-1:0] rdata
);
  import ctt_pkg::*;
  localparam int UPD_BIT = DATA_W - 1;

  logic hit_tick, hit_ival, hit_ctrl, hit_stat, hit_ien, hit_wst;
  assign hit_tick = wr_en && (addr == ADDR_W'(OFS_TICK));
  assign hit_ival = wr_en && (addr == ADDR_W'(OFS_IVAL));
  assign hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign hit_ien  = wr_en && (addr == ADDR_W'(OFS_IEN));
  assign hit_wst  = wr_en && (addr == ADDR_W'(OFS_WST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_div  <= '0;
      ival      <= '0;
      run       <= 1'b0;
      int_start <= 1'b0;
      auto_mode <= 1'b0;
      status    <= 1'b0;
      irq_en    <= 1'b0;
      wstat     <= '0;
    end else begin
      if (hit_tick) tick_div <= wdata[TICK_W-1:0];
      if (hit_ival && wdata[UPD_BIT]) ival <= wdata[IVAL_W-1:0];
      if (hit_ctrl) begin
        run       <= wdata[CTRL_RUN];
        int_start <= wdata[CTRL_IRQ];
        auto_mode <= wdata[CTRL_AUTO];
      end
      if (hit_ien) irq_en <= wdata[0];
      if (expire)                    status <= 1'b1;
      else if (hit_stat && wdata[0]) status <= 1'b0;
      if (hit_wst) wstat <= wstat & ~wdata[3:0];
      if (hit_tick) wstat[WST_TICK] <= 1'b1;
      if (hit_ival) wstat[WST_IVAL] <= 1'b1;
      if (hit_ctrl) wstat[WST_CTRL] <= 1'b1;
      wstat[2] <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFS_TICK): rdata = DATA_W'(tick_div);
      ADDR_W'(OFS_IVAL): rdata = DATA_W'(ival);
      ADDR_W'(OFS_CTRL): rdata = DATA_W'({auto_mode, int_start, run});
      ADDR_W'(OFS_STAT): rdata = DATA_W'(status);
      ADDR_W'(OFS_IEN):  rdata = DATA_W'(irq_en);
      ADDR_W'(OFS_WST):  rdata = DATA_W'(wstat);
      default:           rdata = '0;
    endcase
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TICK_W = 32,
  parameter int IVAL_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [TICK_W-1:0] tick_div;
  logic [IVAL_W-1:0] ival;
  logic run, int_start, auto_mode, status, irq_en;
  logic [3:0] wstat;
  logic tick_w, expire_w;

  ctt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_W(TICK_W), .IVAL_W(IVAL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire_w), .tick_div(tick_div), .ival(ival), .run(run),
    .int_start(int_start), .auto_mode(auto_mode), .status(status),
    .irq_en(irq_en), .wstat(wstat), .rdata(rdata)
  );

  ctt_prescaler #(.TICK_W(TICK_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .div(tick_div), .tick(tick_w)
  );

  ctt_interval #(.IVAL_W(IVAL_W)) u_ival (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_w), .reload(ival),
    .auto_mode(auto_mode), .expire(expire_w)
  );

  assign irq = status && irq_en && int_start;
endmodule

// File: rtl/ctt_checker.sv
module ctt_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IVAL_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              run,
  input logic              tick,
  input logic              expire,
  input logic              status,
  input logic              int_start,
  input logic              auto_mode,
  input logic [3:0]        wstat,
  input logic [IVAL_W-1:0] ival,
  input logic              irq
);
  import ctt_pkg::*;

  assert_status_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status);

  assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_STAT) && wdata[0] && !expire) |=> !status);

  assert_irq_needs_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !int_start |-> !irq);

  assert_single_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !auto_mode) |=> !expire);

  assert_halt_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!tick && !expire));

  assert_ctrl_wstat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_CTRL)) |=> wstat[WST_CTRL]);

  assert_ival_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_IVAL) && !wdata[DATA_W-1]) |=> $stable(ival));
endmodule

bind core_tick_timer ctt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IVAL_W(IVAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .run(run), .tick(tick_w), .expire(expire_w), .status(status),
  .int_start(int_start), .auto_mode(auto_mode), .wstat(wstat), .ival(ival),
  .irq(irq)
);

// File: tb/tb_core_tick_timer.sv
`timescale 1ns/1ps
module tb_core_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  core_tick_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                       .wdata(wdata), .rdata(rdata), .irq(irq));

  typedef struct packed {
    logic [15:0] t;
    logic [31:0] n;
    logic        rep;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{t:16'd1, n:32'd15, rep:1'b1},
    '{t:16'd0, n:32'd16, rep:1'b0},
    '{t:16'd3, n:32'd20, rep:1'b1},
    '{t:16'd2, n:32'd17, rep:1'b0},
    '{t:16'd0, n:32'd15, rep:1'b1}
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  // count edges from the start write until irq rises
  task automatic wait_irq(inout int cnt, input int limit);
    do begin
      @(negedge clk);
      cnt++;
    end while (!irq && cnt < limit);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int cnt;
    longint p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (VEC[i]) begin end
    rd(8'h00, d); check("R1 tick reset", d, 0);
    rd(8'h08, d); check("R1 ival reset", d, 0);
    rd(8'h20, d); check("R1 ctrl reset", d, 0);
    rd(8'h30, d); check("R1 status reset", d, 0);
    rd(8'h34, d); check("R1 enable reset", d, 0);
    rd(8'h40, d); check("R1 wstat reset", d, 0);
    rd(8'h10, d); check("R1 unmapped", d, 0);
    check("R1 irq reset", irq, 0);

    // R3 update-bit guard, R8 write flags
    wr(8'h08, 32'h8000_0020);
    rd(8'h08, d); check("R3 ival loaded", d, 32'h20);
    wr(8'h08, 32'h0000_0055);
    rd(8'h08, d); check("R3 ival unchanged", d, 32'h20);
    rd(8'h40, d); check("R8 ival flag", d, 32'h2);
    wr(8'h40, 32'h0);
    rd(8'h40, d); check("R8 zero write keeps", d, 32'h2);
    wr(8'h40, 32'h2);
    rd(8'h40, d); check("R8 ival flag cleared", d, 0);
    wr(8'h00, 32'h5);
    rd(8'h40, d); check("R8 tick flag", d, 32'h1);
    wr(8'h20, 32'h0);
    rd(8'h40, d); check("R8 ctrl flag", d, 32'h9);
    wr(8'h40, 32'hF);
    rd(8'h40, d); check("R8 all cleared", d, 0);

    // vector table: R2 first period, R7 repeat, R6 single shot
    for (int i = 0; i < NV; i++) begin
      p = longint'(VEC[i].n) * (longint'(VEC[i].t) + 1);
      wr(8'h20, 32'h0);
      wr(8'h30, 32'h1);
      wr(8'h00, 32'(VEC[i].t));
      wr(8'h08, 32'h8000_0000 | VEC[i].n);
      wr(8'h34, 32'h1);
      wr(8'h20, {29'd0, VEC[i].rep, 2'b11});
      cnt = 0;
      wait_irq(cnt, 2000);
      check($sformatf("R2 first period vec%0d", i), cnt, p);
      wr_en = 1'b1; addr = 8'h30; wdata = 32'h1;
      @(negedge clk);
      cnt++;
      wr_en = 1'b0;
      check($sformatf("R5 cleared vec%0d", i), irq, 0);
      if (VEC[i].rep) begin
        wait_irq(cnt, 4000);
        check($sformatf("R7 second period vec%0d", i), cnt, 2 * p);
      end else begin
        repeat (3 * int'(p)) @(negedge clk);
        check($sformatf("R6 no refire vec%0d", i), irq, 0);
      end
    end

    // R4/R5 gating and status persistence
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h8000_0010);
    wr(8'h20, 32'h3);
    repeat (40) @(negedge clk);
    check("R4 enable off blocks irq", irq, 0);
    rd(8'h30, d); check("R5 status set", d, 1);
    wr(8'h34, 32'h1);
    check("R4 irq when all set", irq, 1);
    wr(8'h30, 32'h0);
    rd(8'h30, d); check("R5 zero write keeps status", d, 1);
    wr(8'h20, 32'h1);
    check("R4 int start off blocks irq", irq, 0);
    wr(8'h30, 32'h1);
    rd(8'h30, d); check("R5 status cleared", d, 0);

    // R9 stop holds, restart reloads full period
    wr(8'h20, 32'h0);
    wr(8'h08, 32'h8000_0014);
    wr(8'h20, 32'h7);
    repeat (10) @(negedge clk);
    wr(8'h20, 32'h0);
    repeat (30) @(negedge clk);
    check("R9 stopped no irq", irq, 0);
    wr(8'h20, 32'h7);
    cnt = 0;
    wait_irq(cnt, 2000);
    check("R9 full period after restart", cnt, 20);

    done = 1'b1;
    summary();
  end
endmodule